// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on a single output line. A word enters through a valid/ready stream port into a one-entry holding buffer that sits in front of a frame shifter. The shifter sends a low start bit, then 7, 8 or 9 data bits least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. While no frame is in flight the line rests high.

A small register-write port sets the frame format, the divisor `n` and a send-enable bit. Every bit lasts (n+1)×16 clock cycles. A frame is launched only inside the end-of-frame window, which means when the line is idle or during the last cycle of the final stop bit. Launch needs the enable bit set, a full buffer and, when CTS gating is on, a low clear-to-send input. Because launch is checked in the last cycle of a frame, a word that is buffered in time follows the previous frame with no idle time. Status outputs report an empty buffer and an idle transmitter, and a one-cycle interrupt pulse fires each time the buffer empties.

Stream rules: `in_ready` equals the buffer-empty flag. A word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. While the buffer is full, `in_ready` stays low and the producer must hold its word. The block never drops a word and never overwrites one.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `in_ready` is 1, `tx_empty` is 1 and `tx_irq` is 0. The default format is 8 data bits with no parity and one stop bit, the divisor is 0 and sending is disabled.
- R2: Each bit on `txd`, including the low start bit, lasts exactly (n+1)×16 clock cycles. Here `n` is written at `cfg_addr`=1.
- R3: A frame begins with one low start bit and then sends the buffered data least significant bit first. Mode field [1:0], written at `cfg_addr`=0, selects the data length: 0 gives 7 bits, 1 gives 8, 2 gives 9 and 3 gives 8. Buffer bits above the chosen length are not sent.
- R4: When mode bit [2] is 1, a parity bit follows the data. With mode bit [3]=1 the count of ones over data and parity is odd. With mode bit [3]=0 that count is even.
- R5: The frame ends with one high stop bit, or with two when mode bit [4] is 1.
- R6: A frame starts only while the enable bit (`cfg_addr`=2, bit 0) is 1 and the buffer is full. When mode bit [5] is 1, `cts_n` must also be 0. If any of these conditions fails, `txd` stays high and the word stays in the buffer.
- R7: Once a frame has started, clearing the enable bit or raising `cts_n` does not shorten or stop that frame.
- R8: `in_ready` equals `buf_empty`. `buf_empty` clears when a word is accepted and sets on the edge where the word moves into the shifter. A buffered word does not change while the buffer is full.
- R9: If a word is buffered before the last cycle of the final stop bit, its start bit follows directly, with no idle cycle between the two frames.
- R10: `tx_empty` rises one cycle after the end-of-frame strobe when no further frame launches. It falls when a frame starts, and it stays low across back-to-back frames.
- R11: `tx_irq` is a one-cycle pulse that comes exactly once for each 0-to-1 transition of `buf_empty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 mode, 1 divisor, 2 enable |
| cfg_wdata | input | DIV_W | Register write data |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream ready (buffer empty) |
| in_data | input | 9 | Stream word |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer empty |
| tx_empty | output | 1 | Transmitter idle |
| tx_irq | output | 1 | Buffer-emptied interrupt pulse |

## Verification
The hardest case to reach is the single-cycle launch window at the end of a frame. Two words have to be queued so that the second one lands in the buffer while the first is still shifting out. The stimulus does this by pushing the second word as soon as `in_ready` returns, right after the first word is taken. The bench then checks three things: the two start edges are exactly one frame length apart, `tx_empty` rises only once for the pair, and exactly two interrupt pulses appear. Mid-frame immunity is reached by changing enable and CTS while a frame is on the line, and the scoreboard then demands the complete frame.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = 13;   // start + 9 data + parity + 2 stop
  localparam int CNT_W   = 4;

  typedef enum logic [1:0] {
    LEN7  = 2'd0,
    LEN8  = 2'd1,
    LEN9  = 2'd2,
    LEN8B = 2'd3
  } len_e;

  typedef struct packed {
    logic cts_gate;
    logic two_stop;
    logic par_odd;
    logic par_en;
    len_e len;
  } mode_t;
endpackage

// File: rtl/async_tx_regs.sv
module async_tx_regs
  import async_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [DIV_W-1:0]    cfg_wdata,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  input  logic                take,
  output logic                in_ready,
  output mode_t               mode,
  output logic [DIV_W-1:0]    div_n,
  output logic                en,
  output logic [DATA_W-1:0]   buf_q,
  output logic                buf_empty,
  output logic                irq
);
  logic accept;
  assign in_ready = buf_empty;
  assign accept   = in_valid && buf_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '{cts_gate: 1'b0, two_stop: 1'b0, par_odd: 1'b0, par_en: 1'b0, len: LEN8};
      div_n <= '0;
      en    <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    mode  <= mode_t'(cfg_wdata[5:0]);
        2'd1:    div_n <= cfg_wdata;
        2'd2:    en    <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      buf_empty <= 1'b1;
      irq       <= 1'b0;
    end else begin
      irq <= take;
      if (accept) begin
        buf_q     <= in_data;
        buf_empty <= 1'b0;
      end else if (take) begin
        buf_empty <= 1'b1;
      end
    end
  end

  a_r11_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (buf_empty && !$past(buf_empty)));
  a_r8_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_empty |=> $stable(buf_q));
endmodule

// File: rtl/async_tx_div.sv
module async_tx_div #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  output logic             bit_end
);
  localparam int SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] pre;
  logic [SUB_W-1:0] sub;
  logic             pre_wrap;

  assign pre_wrap = (pre >= div_n);
  assign bit_end  = pre_wrap && (sub == SUB_W'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      sub <= '0;
    end else if (restart) begin
      pre <= '0;
      sub <= '0;
    end else if (pre_wrap) begin
      pre <= '0;
      sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  a_r2_bit_end_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !bit_end);
endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
  import async_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic              en,
  input  logic              cts_n,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              bit_end,
  output logic              take,
  output logic              restart,
  output logic              txd,
  output logic              tx_empty
);
  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic               tend, tend_hi, go;
  logic [FRAME_W-1:0] vec;
  logic [CNT_W-1:0]   nbits;

  always_comb begin
    int nd;
    int pos;
    logic par;
    nd  = (mode.len == LEN7) ? 7 : (mode.len == LEN9) ? 9 : 8;
    par = mode.par_odd;
    vec = '1;
    vec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        vec[1 + i] = buf_data[i];
        par        = par ^ buf_data[i];
      end
    end
    pos = 1 + nd;
    if (mode.par_en) begin
      vec[pos] = par;
      pos      = pos + 1;
    end
    nbits = CNT_W'(pos + (mode.two_stop ? 2 : 1));
  end

  assign tend    = busy && bit_end && (left == '0);
  assign tend_hi = !busy || tend;
  assign go      = tend_hi && en && !buf_empty && (!mode.cts_gate || !cts_n);
  assign take    = go;
  assign restart = tend_hi;
  assign txd     = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sh       <= '1;
      left     <= '0;
      tx_empty <= 1'b1;
    end else begin
      tx_empty <= tend_hi && !go;
      if (go) begin
        busy <= 1'b1;
        sh   <= vec;
        left <= nbits - 1'b1;
      end else if (busy && bit_end) begin
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - 1'b1;
        end
      end
    end
  end

  a_r7_no_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tend) |=> busy);
  a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && !buf_empty));
  a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (txd && !busy));
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [8:0]       in_data,
  input  logic             cts_n,
  output logic             txd,
  output logic             buf_empty,
  output logic             tx_empty,
  output logic             tx_irq
);
  mode_t             mode;
  logic [DIV_W-1:0]  div_n;
  logic              en, take, restart, bit_end;
  logic [DATA_W-1:0] buf_q;

  async_tx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .take(take), .in_ready(in_ready), .mode(mode), .div_n(div_n),
    .en(en), .buf_q(buf_q), .buf_empty(buf_empty), .irq(tx_irq)
  );

  async_tx_div #(.DIV_W(DIV_W), .OVS(16)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div_n(div_n),
    .bit_end(bit_end)
  );

  async_tx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .mode(mode), .en(en), .cts_n(cts_n),
    .buf_empty(buf_empty), .buf_data(buf_q), .bit_end(bit_end),
    .take(take), .restart(restart), .txd(txd), .tx_empty(tx_empty)
  );
endmodule

// File: tb/test_async_tx.sv
module test_async_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic cts_n = 1'b0;
  logic in_ready, txd, buf_empty, tx_empty, tx_irq;

  always #10 clk = ~clk;

  async_tx #(.DIV_W(8)) i_async_tx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cts_n(cts_n), .txd(txd), .buf_empty(buf_empty),
    .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  typedef struct {
    logic [8:0] d;
    logic [1:0] len;
    logic pe, po, two;
    int p;
  } item_t;

  item_t exp_q[$];
  int start_cyc[$];
  int checks = 0, fails = 0;
  int cyc = 0;
  int cur_p = 16;
  logic [5:0] cur_mode = 6'b000001;
  int sent = 0, irqs = 0, te_rises = 0, te_rise_cyc = 0;
  logic te_prev = 1'b1, be_prev = 1'b1;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 2'd0) cur_mode = d[5:0];
    if (a == 2'd1) cur_p = (int'(d) + 1) * 16;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [8:0] d);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    it.d = d; it.len = cur_mode[1:0]; it.pe = cur_mode[2];
    it.po = cur_mode[3]; it.two = cur_mode[4]; it.p = cur_p;
    exp_q.push_back(it);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic int build(input item_t it, output logic [12:0] v);
    int nd, k, ones;
    nd = (it.len == 2'd0) ? 7 : (it.len == 2'd2) ? 9 : 8;
    v = '1; v[0] = 1'b0; ones = 0;
    for (int i = 0; i < nd; i++) begin
      v[1 + i] = it.d[i];
      if (it.d[i]) ones++;
    end
    k = 1 + nd;
    if (it.pe) begin
      v[k] = it.po ? ((ones % 2) == 0) : ((ones % 2) == 1);
      k++;
    end
    return k + (it.two ? 2 : 1);
  endfunction

  // scoreboard monitor: R3 R4 R5 frame content
  item_t mit;
  logic [12:0] mexp, mgot;
  int mnb;
  logic mprev = 1'b1;
  always begin
    @(negedge clk);
    if (!rst_n) mprev = 1'b1;
    else if (mprev && !txd) begin
      start_cyc.push_back(cyc);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected frame", 1, 0);
        mprev = 1'b0;
      end else begin
        mit = exp_q.pop_front();
        mnb = build(mit, mexp);
        mgot = '1;
        repeat (mit.p / 2) @(negedge clk);
        for (int k = 0; k < mnb; k++) begin
          mgot[k] = txd;
          if (k != mnb - 1) repeat (mit.p) @(negedge clk);
        end
        chk(mgot == mexp, "R3 R4 R5 frame bits", int'(mgot), int'(mexp));
        repeat (mit.p - mit.p / 2 - 1) @(negedge clk);
        mprev = txd;
      end
    end else mprev = txd;
  end

  // R11 interrupt and R10 empty-flag observers
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_irq) begin
        irqs++;
        chk(buf_empty && !be_prev, "R11 irq on buffer-empty rise", int'(be_prev), 0);
      end
      if (tx_empty && !te_prev) begin
        te_rises++;
        te_rise_cyc = cyc;
      end
    end
    be_prev = buf_empty;
    te_prev = tx_empty;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 150000);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cnt, r0;
    bit idle_ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(buf_empty && in_ready, "R1 buffer empty/ready", int'(buf_empty), 1);
    chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
    chk(tx_irq == 1'b0, "R1 irq", int'(tx_irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd && tx_empty, "R1 idle after reset release", int'(txd), 1);

    // R2 bit period at three divisors (8N1, data 0x01 -> low for start bit only)
    cfg(2'd0, 8'h01);
    cfg(2'd2, 8'h01);
    for (int dv = 0; dv < 3; dv++) begin
      cfg(2'd1, 8'((dv == 2) ? 3 : dv));
      send(9'h001);
      while (txd) @(negedge clk);
      cnt = 0;
      while (!txd) begin cnt++; @(negedge clk); end
      chk(cnt == cur_p, "R2 start bit length", cnt, cur_p);
      wait_idle();
    end

    // R3 R4 R5 formats
    cfg(2'd1, 8'd1);
    cfg(2'd0, 8'h01); send(9'h0A5); wait_idle();              // 8N1
    cfg(2'd0, 8'h04); send(9'h1D3); wait_idle();              // 7 bits even, R3 upper ignored
    cfg(2'd0, 8'h1E); send(9'h155); send(9'h0AA); wait_idle(); // 9 bits odd 2 stop
    cfg(2'd0, 8'h0D); send(9'h100); wait_idle();              // 8 odd, R3 bit 8 ignored
    cfg(2'd0, 8'h15); send(9'h0FF); wait_idle();              // 8 even 2 stop
    cfg(2'd0, 8'h03); send(9'h13C); wait_idle();              // code 3 -> 8 bits

    // R6 gating: enable off, then CTS high
    cfg(2'd0, 8'h21);
    cfg(2'd2, 8'h00);
    cts_n = 1'b1;
    send(9'h03C);
    idle_ok = 1'b1;
    repeat (300) begin @(negedge clk); if (!txd) idle_ok = 1'b0; end
    chk(idle_ok, "R6 no start while disabled", 0, 1);
    chk(!in_ready && !buf_empty, "R8 buffer held full", int'(in_ready), 0);
    cfg(2'd2, 8'h01);
    repeat (300) begin @(negedge clk); if (!txd) idle_ok = 1'b0; end
    chk(idle_ok && !buf_empty, "R6 no start while CTS high", int'(buf_empty), 0);
    cts_n = 1'b0;
    wait_idle();
    chk(buf_empty && in_ready, "R8 buffer emptied by launch", int'(buf_empty), 1);

    // R7 mid-frame changes ignored
    send(9'h096);
    while (txd) @(negedge clk);
    repeat (3 * cur_p) @(negedge clk);
    cfg(2'd2, 8'h00);
    cts_n = 1'b1;
    chk(!tx_empty, "R7 frame still running", int'(tx_empty), 0);
    wait_idle();
    chk(exp_q.size() == 0, "R7 frame completed", exp_q.size(), 0);
    cts_n = 1'b0;
    cfg(2'd2, 8'h01);

    // R9 R10 back-to-back
    cfg(2'd0, 8'h01);
    start_cyc.delete();
    r0 = te_rises;
    send(9'h05A);
    send(9'h0C3);
    wait_idle();
    chk(start_cyc.size() == 2, "R9 two frames", start_cyc.size(), 2);
    if (start_cyc.size() == 2) begin
      chk(start_cyc[1] - start_cyc[0] == 10 * cur_p, "R9 no idle gap",
          start_cyc[1] - start_cyc[0], 10 * cur_p);
      chk(te_rise_cyc - start_cyc[1] == 10 * cur_p, "R10 tx_empty one cycle after end",
          te_rise_cyc - start_cyc[1], 10 * cur_p);
    end
    chk(te_rises == r0 + 1, "R10 tx_empty stays low between frames", te_rises - r0, 1);

    // R11 pulse count
    chk(irqs == sent, "R11 one irq per frame", irqs, sent);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule